// File: doc/BRIEF.md
# Battery Voltage Calibration Datapath

This block converts one raw battery-voltage sample from a 10-bit converter into a calibrated reading. The reading has two parts: a whole number of millivolts, and a fraction expressed in millionths of a millivolt. A calibration byte carries two signed 4-bit trims. The upper nibble is a zero-offset in whole codes, and it is removed first. The lower nibble is a gain trim in steps of 0.0015, and it is applied as a ratio over 10000. The corrected code is then scaled by exactly 4.6875 mV per code.

Every division truncates toward zero, as integer division in software does, so results match a software model bit for bit. Both divisions by 10000 share one sequential restoring divider that retires one quotient bit per cycle. A caller presents a sample when `busy` is low. It then waits for the single-cycle `out_valid` strobe. The outputs keep their value until the next result.

Top module: `vbat_cal_top`

## Requirements
- R1: Only bits 9:0 of `raw_word` take part in the result. Bits 15:10 have no effect on `mv_out` or `frac_out`.
- R2: Bits 7:4 of `cal_byte` are a two's-complement offset in the range -8..7. This offset is subtracted from the raw code before any other step.
- R3: Bits 3:0 of `cal_byte` are a two's-complement gain trim g in the range -8..7. The offset-corrected value is multiplied by (10000 - 15*g) and then divided by 10000, truncating toward zero.
- R4: The gain-corrected value is multiplied by 46875. `mv_out` is that product divided by 10000, truncated toward zero. `frac_out` is the remainder of the same division times 100.
- R5: A negative intermediate keeps its sign through every stage. A negative result gives a non-positive `mv_out` and a remainder with the sign of the dividend.
- R6: A sample is taken when `in_valid` is high while `busy` is low. `busy` is high from the next cycle until the result appears. `in_valid`, `raw_word` and `cal_byte` are ignored while `busy` is high.
- R7: `out_valid` is high for exactly one cycle per accepted sample. `busy` is low in that same cycle.
- R8: `mv_out` and `frac_out` change only in a cycle where `out_valid` is high.
- R9: During reset, `busy`, `out_valid`, `mv_out` and `frac_out` are all zero.
- R10: Every result has `frac_out` as a multiple of 100 within -999900..999900. A non-zero `frac_out` has the same sign as the final product, so it never opposes the sign of a non-zero `mv_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample present; taken when `busy` is low |
| raw_word | input | 16 | Raw converter word; bits 9:0 are the code |
| cal_byte | input | 8 | Offset trim in 7:4, gain trim in 3:0 |
| busy | output | 1 | A result is pending; new samples are ignored |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| mv_out | output | 32 | Signed whole millivolts |
| frac_out | output | 32 | Signed fraction in millionths of a millivolt |

## Verification
The properties assume that a sample is offered only while `busy` is low, or that extra strobes during `busy` are truly discarded. They also assume that the trims stay within their nibble ranges, so that no intermediate exceeds the divider's magnitude width. The stimulus waits for `busy` to fall before each sample. It deliberately drives inverted data with `in_valid` high during some conversions, and drops the strobe well before the result returns. Raw codes reach at most 1023 and the trims are full nibbles, so every product stays far below the 27-bit magnitude that the divider handles.

// File: rtl/vbat_cal_pkg.sv
package vbat_cal_pkg;
  localparam int RAW_IN_W  = 16;
  localparam int RAW_W     = 10;
  localparam int CAL_W     = 8;
  localparam int DATA_W    = 32;
  localparam int MAG_W     = 27;
  localparam int GAIN_DIV  = 10000;
  localparam int GAIN_STEP = 15;
  localparam int SCALE_NUM = 46875;
  localparam int FRAC_MUL  = 100;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DIV_GAIN,
    ST_DIV_SCALE
  } cal_state_e;
endpackage

// File: rtl/vbat_trim_stage.sv
module vbat_trim_stage
  import vbat_cal_pkg::*;
#(
  parameter int RAW_W_P  = RAW_W,
  parameter int CAL_W_P  = CAL_W,
  parameter int DATA_W_P = DATA_W,
  parameter int DIV_P    = GAIN_DIV,
  parameter int STEP_P   = GAIN_STEP
) (
  input  logic [RAW_W_P-1:0]         raw_code,
  input  logic [CAL_W_P-1:0]         cal_byte,
  output logic signed [DATA_W_P-1:0] gain_product
);
  localparam int HALF_W = CAL_W_P / 2;
  localparam logic signed [DATA_W_P-1:0] DIV_S  = DATA_W_P'(DIV_P);
  localparam logic signed [DATA_W_P-1:0] STEP_S = DATA_W_P'(STEP_P);

  logic [HALF_W-1:0]          offs_nib;
  logic [HALF_W-1:0]          gain_nib;
  logic signed [DATA_W_P-1:0] offs_s;
  logic signed [DATA_W_P-1:0] gain_s;
  logic signed [DATA_W_P-1:0] raw_s;
  logic signed [DATA_W_P-1:0] corr_s;
  logic signed [DATA_W_P-1:0] factor_s;

  assign offs_nib = cal_byte[CAL_W_P-1:HALF_W];
  assign gain_nib = cal_byte[HALF_W-1:0];

  always_comb begin
    offs_s       = $signed({{(DATA_W_P-HALF_W){offs_nib[HALF_W-1]}}, offs_nib});
    gain_s       = $signed({{(DATA_W_P-HALF_W){gain_nib[HALF_W-1]}}, gain_nib});
    raw_s        = $signed({{(DATA_W_P-RAW_W_P){1'b0}}, raw_code});
    corr_s       = raw_s - offs_s;
    factor_s     = DIV_S - (gain_s * STEP_S);
    gain_product = corr_s * factor_s;
  end
endmodule

// File: rtl/vbat_const_mul.sv
module vbat_const_mul
  import vbat_cal_pkg::*;
#(
  parameter int DATA_W_P = DATA_W,
  parameter int FACTOR_P = 1
) (
  input  logic signed [DATA_W_P-1:0] mul_in,
  output logic signed [DATA_W_P-1:0] mul_out
);
  localparam logic signed [DATA_W_P-1:0] K_S = DATA_W_P'(FACTOR_P);

  assign mul_out = mul_in * K_S;
endmodule

// File: rtl/vbat_seq_div.sv
module vbat_seq_div
  import vbat_cal_pkg::*;
#(
  parameter int DATA_W_P  = DATA_W,
  parameter int MAG_W_P   = MAG_W,
  parameter int DIVISOR_P = GAIN_DIV
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic signed [DATA_W_P-1:0] dividend,
  output logic                       done,
  output logic signed [DATA_W_P-1:0] quotient,
  output logic signed [DATA_W_P-1:0] remainder
);
  localparam int REM_W = $clog2(DIVISOR_P) + 1;
  localparam int CNT_W = $clog2(MAG_W_P + 1);
  localparam logic [REM_W-1:0] DIV_U = REM_W'(DIVISOR_P);

  logic               running_q, running_d;
  logic               done_q, done_d;
  logic               neg_q, neg_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [MAG_W_P-1:0] acc_q, acc_d;
  logic [REM_W-2:0]   part_q, part_d;

  logic [DATA_W_P-1:0] dvd_abs;
  logic [REM_W-1:0]    trial;
  logic [REM_W-1:0]    trial_diff;
  logic                unused_abs_hi;
  logic                unused_diff_msb;
  logic [DATA_W_P-1:0] quot_mag;
  logic [DATA_W_P-1:0] rem_mag;

  assign dvd_abs         = dividend[DATA_W_P-1] ? (-dividend) : dividend;
  assign unused_abs_hi   = ^dvd_abs[DATA_W_P-1:MAG_W_P];
  assign trial           = {part_q, acc_q[MAG_W_P-1]};
  assign trial_diff      = trial - DIV_U;
  assign unused_diff_msb = trial_diff[REM_W-1];

  always_comb begin
    running_d = running_q;
    done_d    = 1'b0;
    neg_d     = neg_q;
    cnt_d     = cnt_q;
    acc_d     = acc_q;
    part_d    = part_q;
    if (start) begin
      running_d = 1'b1;
      neg_d     = dividend[DATA_W_P-1];
      cnt_d     = CNT_W'(MAG_W_P);
      acc_d     = dvd_abs[MAG_W_P-1:0];
      part_d    = '0;
    end else if (running_q) begin
      if (trial >= DIV_U) begin
        part_d = trial_diff[REM_W-2:0];
        acc_d  = {acc_q[MAG_W_P-2:0], 1'b1};
      end else begin
        part_d = trial[REM_W-2:0];
        acc_d  = {acc_q[MAG_W_P-2:0], 1'b0};
      end
      cnt_d = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        running_d = 1'b0;
        done_d    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      done_q    <= 1'b0;
      neg_q     <= 1'b0;
      cnt_q     <= '0;
      acc_q     <= '0;
      part_q    <= '0;
    end else begin
      running_q <= running_d;
      done_q    <= done_d;
      neg_q     <= neg_d;
      cnt_q     <= cnt_d;
      acc_q     <= acc_d;
      part_q    <= part_d;
    end
  end

  assign quot_mag  = {{(DATA_W_P-MAG_W_P){1'b0}}, acc_q};
  assign rem_mag   = {{(DATA_W_P-REM_W+1){1'b0}}, part_q};
  assign quotient  = neg_q ? $signed(-quot_mag) : $signed(quot_mag);
  assign remainder = neg_q ? $signed(-rem_mag) : $signed(rem_mag);
  assign done      = done_q;
endmodule

// File: rtl/vbat_cal_top.sv
module vbat_cal_top
  import vbat_cal_pkg::*;
#(
  parameter int RAW_IN_W_P = RAW_IN_W,
  parameter int RAW_W_P    = RAW_W,
  parameter int CAL_W_P    = CAL_W,
  parameter int DATA_W_P   = DATA_W,
  parameter int MAG_W_P    = MAG_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [RAW_IN_W_P-1:0]      raw_word,
  input  logic [CAL_W_P-1:0]         cal_byte,
  output logic                       busy,
  output logic                       out_valid,
  output logic signed [DATA_W_P-1:0] mv_out,
  output logic signed [DATA_W_P-1:0] frac_out
);
  cal_state_e state_q, state_d;

  logic                       unused_raw_hi;
  logic signed [DATA_W_P-1:0] gain_product;
  logic signed [DATA_W_P-1:0] scaled;
  logic signed [DATA_W_P-1:0] frac_calc;
  logic signed [DATA_W_P-1:0] div_in;
  logic signed [DATA_W_P-1:0] div_quot;
  logic signed [DATA_W_P-1:0] div_rem;
  logic                       div_start;
  logic                       div_done;
  logic                       out_load;
  logic                       valid_q;
  logic signed [DATA_W_P-1:0] mv_q;
  logic signed [DATA_W_P-1:0] frac_q;

  assign unused_raw_hi = ^raw_word[RAW_IN_W_P-1:RAW_W_P];

  vbat_trim_stage #(
    .RAW_W_P (RAW_W_P),
    .CAL_W_P (CAL_W_P),
    .DATA_W_P(DATA_W_P),
    .DIV_P   (GAIN_DIV),
    .STEP_P  (GAIN_STEP)
  ) u_trim (
    .raw_code    (raw_word[RAW_W_P-1:0]),
    .cal_byte    (cal_byte),
    .gain_product(gain_product)
  );

  vbat_seq_div #(
    .DATA_W_P (DATA_W_P),
    .MAG_W_P  (MAG_W_P),
    .DIVISOR_P(GAIN_DIV)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (div_in),
    .done     (div_done),
    .quotient (div_quot),
    .remainder(div_rem)
  );

  vbat_const_mul #(
    .DATA_W_P(DATA_W_P),
    .FACTOR_P(SCALE_NUM)
  ) u_scale (
    .mul_in (div_quot),
    .mul_out(scaled)
  );

  vbat_const_mul #(
    .DATA_W_P(DATA_W_P),
    .FACTOR_P(FRAC_MUL)
  ) u_frac (
    .mul_in (div_rem),
    .mul_out(frac_calc)
  );

  always_comb begin
    state_d   = state_q;
    div_start = 1'b0;
    div_in    = gain_product;
    out_load  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          div_start = 1'b1;
          div_in    = gain_product;
          state_d   = ST_DIV_GAIN;
        end
      end
      ST_DIV_GAIN: begin
        if (div_done) begin
          div_start = 1'b1;
          div_in    = scaled;
          state_d   = ST_DIV_SCALE;
        end
      end
      ST_DIV_SCALE: begin
        if (div_done) begin
          out_load = 1'b1;
          state_d  = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      valid_q <= out_load;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mv_q   <= '0;
      frac_q <= '0;
    end else if (out_load) begin
      mv_q   <= div_quot;
      frac_q <= frac_calc;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign out_valid = valid_q;
  assign mv_out    = mv_q;
  assign frac_out  = frac_q;
endmodule

// File: rtl/vbat_cal_chk.sv
module vbat_cal_chk #(
  parameter int DATA_W_P = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       busy,
  input logic                       out_valid,
  input logic signed [DATA_W_P-1:0] mv_out,
  input logic signed [DATA_W_P-1:0] frac_out
);
  p_busy_on_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !busy) |=> busy);

  p_valid_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_idle_with_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!busy && $past(busy)));

  p_fell_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> out_valid);

  p_outputs_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(mv_out) && $stable(frac_out)));

  p_frac_grid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((frac_out % 100 == 0) && (frac_out <= 999900) && (frac_out >= -999900)));

  p_frac_sign_pos_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (mv_out > 0)) |-> (frac_out >= 0));

  p_frac_sign_neg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (mv_out < 0)) |-> (frac_out <= 0));
endmodule

bind vbat_cal_top vbat_cal_chk #(.DATA_W_P(DATA_W_P)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .busy     (busy),
  .out_valid(out_valid),
  .mv_out   (mv_out),
  .frac_out (frac_out)
);

// File: tb/tb_vbat_cal_top.sv
module tb_vbat_cal_top;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] raw_word;
  logic [7:0]  cal_byte;
  logic        busy;
  logic        out_valid;
  logic signed [31:0] mv_out;
  logic signed [31:0] frac_out;

  int n_tests;
  int n_fail;
  int n_samples;

  vbat_cal_top dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .raw_word (raw_word),
    .cal_byte (cal_byte),
    .busy     (busy),
    .out_valid(out_valid),
    .mv_out   (mv_out),
    .frac_out (frac_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void ref_calc(input int raw, input int cal, output int mv, output int fr);
    int zse;
    int ge;
    int v;
    zse = (cal >> 4) & 15;
    if (zse > 7) zse -= 16;
    ge = cal & 15;
    if (ge > 7) ge -= 16;
    v  = raw - zse;
    v  = v * (10000 - ge * 15) / 10000;
    v  = v * 46875;
    mv = v / 10000;
    fr = (v % 10000) * 100;
  endfunction

  task automatic run_sample(input logic [15:0] rw, input logic [7:0] cb,
                            input string tag, input bit disturb);
    int exp_mv;
    int exp_fr;
    int wait_cnt;
    int held_mv;
    int held_fr;
    ref_calc(int'(rw[9:0]), int'(cb), exp_mv, exp_fr);
    @(negedge clk);
    while (busy) @(negedge clk);
    in_valid = 1'b1;
    raw_word = rw;
    cal_byte = cb;
    @(negedge clk);
    in_valid = disturb;
    raw_word = ~rw;
    cal_byte = ~cb;
    if (disturb) chk("R6 busy after accept", int'(busy), 1);
    wait_cnt = 0;
    while (!out_valid && wait_cnt < 400) begin
      @(negedge clk);
      wait_cnt++;
      if (wait_cnt >= 3) in_valid = 1'b0;
    end
    in_valid = 1'b0;
    n_samples++;
    if (!out_valid) begin
      n_tests++;
      n_fail++;
      $display("FAIL R6 no result actual=0 expected=1");
    end else begin
      chk({tag, " mv"}, mv_out, exp_mv);
      chk({tag, " frac"}, frac_out, exp_fr);
      if (disturb) begin
        chk("R7 busy low with valid", int'(busy), 0);
        held_mv = mv_out;
        held_fr = frac_out;
        @(negedge clk);
        chk("R7 single-cycle valid", int'(out_valid), 0);
        repeat (3) @(negedge clk);
        chk("R8 mv held", mv_out, held_mv);
        chk("R8 frac held", frac_out, held_fr);
      end
    end
  endtask

  initial begin
    #1950000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int sd;
    n_tests   = 0;
    n_fail    = 0;
    n_samples = 0;
    sd = $urandom(32'd20240611);
    rst_n    = 1'b0;
    in_valid = 1'b0;
    raw_word = '0;
    cal_byte = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 busy", int'(busy), 0);
    chk("R9 out_valid", int'(out_valid), 0);
    chk("R9 mv", mv_out, 0);
    chk("R9 frac", frac_out, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 negative path: raw 0, offset +7 -> -32 mV, -812500
    run_sample(16'h0000, 8'h70, "R5 negative", 1'b1);
    chk("R5 direct mv", mv_out, -32);
    run_sample(16'h0003, 8'h7F, "R5 small negative", 1'b1);
    // R4 top of range with strongest gain
    run_sample(16'h03FF, 8'h08, "R4 full scale", 1'b1);
    chk("R4 direct mv", mv_out, 4851);
    chk("R10 frac grid", frac_out % 100, 0);
    // R1 upper raw bits ignored
    run_sample(16'hFC05, 8'h00, "R1 high bits set", 1'b1);
    run_sample(16'h0005, 8'h00, "R1 high bits clear", 1'b0);
    run_sample(16'hA5FF, 8'h8F, "R1 mixed", 1'b1);

    // R2 offset sweep and R3 gain sweep over every calibration byte
    for (int c = 0; c < 256; c++) begin
      run_sample(16'd512, 8'(c), "R2 cal sweep", (c % 16) == 0);
      run_sample(16'd37, 8'(c), "R3 cal sweep", 1'b0);
    end

    // R4 every raw code with a rotating calibration byte
    for (int r = 0; r < 1024; r++) begin
      run_sample(16'(r), 8'(r * 37), "R4 raw sweep", (r % 64) == 0);
    end

    // R1/R6 random mix
    for (int k = 0; k < 200; k++) begin
      run_sample(16'($urandom), 8'($urandom), "R1 random", ($urandom % 8) == 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule